// File: doc/BRIEF.md
# Raster Timing Generator with Border Fill

The block produces the scan timing of one display output from a set of programmed horizontal and vertical parameters. A horizontal counter runs across each line, and a flat position counter runs across the whole frame in pixel clocks. All vertical limits are compared against that flat position: frame length, vertical sync width, and the start and end of the display and active windows. Each limit is a line count multiplied by the line period, plus any skew the programmer wants to add. From these comparisons the block drives horizontal sync, vertical sync, a display-enable, an active-data flag and a one-clock fetch pulse. It also reports a frame counter and a line counter.

The active image may be smaller than the display window. Inside the display window, pixels that fall outside the active window are filled with a programmable border colour. Active pixels are taken from an input stream through a valid/ready handshake. When the stream has no valid data for an active pixel, the block shows a programmable underflow colour instead. The timing parameters and the three control flags pass through a shadow stage that is loaded only on the first clock of a frame. The colours and the polarity bits act immediately.

Top module: `vtg_top`

## Requirements
- R1: `hsync_ctl_i` holds the line period in clocks in bits 31:16 and the sync width in bits 15:0. Each line lasts one period, and horizontal sync is active during the first (width) clocks of the line.
- R2: A frame lasts `frame_len_i` clocks, which must be a whole number of lines. Vertical sync is active while the frame position is below `vs_len_i`.
- R3: Display-enable is active when the frame position lies in [`disp_vstart_i`, `disp_vend_i`] and the position within the line lies in [start, end] of `disp_hwin_i`. Both ranges are inclusive, and the window word holds the end in bits 31:16 and the start in bits 15:0.
- R4: `ctrl_i[0]` limits the active window horizontally to `act_hwin_i`, which uses the same field layout as the display window. `ctrl_i[1]` limits it vertically to [`act_vstart_i`, `act_vend_i`]. A pixel inside the display window but outside the active window takes `border_clr_i`. A pixel outside the display window is zero.
- R5: For an active pixel, `pix_ready_o` and `act_o` are high. The output is `pix_data_i` when `pix_valid_i` is high and `underflow_clr_i` otherwise. `pix_ready_o` is low for every other pixel.
- R6: `polarity_i` inverts outputs as follows: bit 0 inverts horizontal sync, bit 1 inverts vertical sync, and bit 2 inverts display-enable.
- R7: The generator starts at frame position 0 in the cycle after `en_i` is first sampled high. While `en_i` is sampled low, the frame and line counters read zero, no fetch pulse is issued, and the syncs and display-enable sit at their inactive levels.
- R8: When `ctrl_i[2]` is set, `fetch_o` pulses for one clock at frame position `fetch_pos_i`.
- R9: The frame counter increments on the first clock of every frame and reads 1 in the first frame after enable. The line counter is 0 on the first line of a frame and increments at each line start.
- R10: Timing words and `ctrl_i` are captured only on the first clock of a frame. A change made mid-frame takes effect in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Master enable |
| hsync_ctl_i | input | 32 | Line period [31:16], sync width [15:0] |
| disp_hwin_i | input | 32 | Display window end [31:16], start [15:0] |
| act_hwin_i | input | 32 | Active window end [31:16], start [15:0] |
| ctrl_i | input | 3 | [0] active H limit, [1] active V limit, [2] fetch enable |
| frame_len_i | input | OFS_W | Frame length in clocks |
| vs_len_i | input | OFS_W | Vertical sync width in clocks |
| disp_vstart_i | input | OFS_W | Display window first position |
| disp_vend_i | input | OFS_W | Display window last position |
| act_vstart_i | input | OFS_W | Active window first position |
| act_vend_i | input | OFS_W | Active window last position |
| fetch_pos_i | input | OFS_W | Fetch pulse position |
| polarity_i | input | 3 | Output inversion bits |
| border_clr_i | input | PIX_W | Border colour |
| underflow_clr_i | input | PIX_W | Starvation colour |
| pix_data_i | input | PIX_W | Stream pixel |
| pix_valid_i | input | 1 | Stream pixel valid |
| pix_ready_o | output | 1 | Stream pixel consumed |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| den_o | output | 1 | Display-enable |
| act_o | output | 1 | Active-data flag |
| fetch_o | output | 1 | Fetch-start pulse |
| pix_o | output | PIX_W | Output pixel |
| frame_cnt_o | output | FCNT_W | Frame counter |
| line_cnt_o | output | 16 | Line counter |

## Verification
The first pattern uses a full-size image with the stream always valid. It separates the sync and display-window decoding from any border or starvation effect. The second pattern enables both active-window limits, a fetch pulse and a stream that starves every third clock, so border, live and underflow pixels are told apart within the same frame. Inverted polarity checks each output's inversion bit on its own. A geometry change written halfway through a frame, followed by a disable and re-enable, shows whether the shadow boundary and the counter restart are honoured.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  parameter int unsigned H_W   = 16;
  parameter int unsigned OFS_W = 24;

  typedef struct packed {
    logic [H_W-1:0]   h_period;
    logic [H_W-1:0]   h_pulse;
    logic [H_W-1:0]   dh_start;
    logic [H_W-1:0]   dh_end;
    logic [H_W-1:0]   ah_start;
    logic [H_W-1:0]   ah_end;
    logic [OFS_W-1:0] f_len;
    logic [OFS_W-1:0] vs_len;
    logic [OFS_W-1:0] dv_start;
    logic [OFS_W-1:0] dv_end;
    logic [OFS_W-1:0] av_start;
    logic [OFS_W-1:0] av_end;
    logic [OFS_W-1:0] fetch_pos;
    logic             ah_en;
    logic             av_en;
    logic             fetch_en;
  } vtg_timing_t;
endpackage

// File: rtl/vtg_shadow.sv
module vtg_shadow
  import vtg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  vtg_timing_t raw_i,
  output vtg_timing_t sh_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_o <= '0;
    else if (load_i) sh_o <= raw_i;
  end
endmodule

// File: rtl/vtg_counters.sv
module vtg_counters
  import vtg_pkg::*;
#(
  parameter int unsigned FCNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  vtg_timing_t       sh_i,
  output logic              run_o,
  output logic              load_o,
  output logic [OFS_W-1:0]  pos_o,
  output logic [H_W-1:0]    h_o,
  output logic [H_W-1:0]    line_o,
  output logic [FCNT_W-1:0] frame_o
);
  logic frame_last, line_last;

  assign frame_last = (pos_o == sh_i.f_len - 1'b1);
  assign line_last  = (h_o == sh_i.h_period - 1'b1);
  // first clock of a frame: enable edge or wrap of the previous frame
  assign load_o     = en_i & (~run_o | frame_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o <= 1'b0; pos_o <= '0; h_o <= '0; line_o <= '0; frame_o <= '0;
    end else if (!en_i) begin
      run_o <= 1'b0; pos_o <= '0; h_o <= '0; line_o <= '0; frame_o <= '0;
    end else if (load_o) begin
      run_o   <= 1'b1;
      pos_o   <= '0;
      h_o     <= '0;
      line_o  <= '0;
      frame_o <= frame_o + 1'b1;
    end else begin
      pos_o <= pos_o + 1'b1;
      if (line_last) begin
        h_o    <= '0;
        line_o <= line_o + 1'b1;
      end else begin
        h_o <= h_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vtg_window.sv
module vtg_window #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic         in_o
);
  assign in_o = (val_i >= lo_i) && (val_i <= hi_i);
endmodule

// File: rtl/vtg_pixel.sv
module vtg_pixel #(
  parameter int unsigned PIX_W = 24
) (
  input  logic             den_i,
  input  logic             act_i,
  input  logic             valid_i,
  input  logic [PIX_W-1:0] data_i,
  input  logic [PIX_W-1:0] border_i,
  input  logic [PIX_W-1:0] underflow_i,
  output logic [PIX_W-1:0] pix_o
);
  always_comb begin
    if (!den_i)        pix_o = '0;
    else if (!act_i)   pix_o = border_i;
    else if (valid_i)  pix_o = data_i;
    else               pix_o = underflow_i;
  end
endmodule

// File: rtl/vtg_top.sv
module vtg_top
  import vtg_pkg::*;
#(
  parameter int unsigned PIX_W  = 24,
  parameter int unsigned FCNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [31:0]       hsync_ctl_i,
  input  logic [31:0]       disp_hwin_i,
  input  logic [31:0]       act_hwin_i,
  input  logic [2:0]        ctrl_i,
  input  logic [OFS_W-1:0]  frame_len_i,
  input  logic [OFS_W-1:0]  vs_len_i,
  input  logic [OFS_W-1:0]  disp_vstart_i,
  input  logic [OFS_W-1:0]  disp_vend_i,
  input  logic [OFS_W-1:0]  act_vstart_i,
  input  logic [OFS_W-1:0]  act_vend_i,
  input  logic [OFS_W-1:0]  fetch_pos_i,
  input  logic [2:0]        polarity_i,
  input  logic [PIX_W-1:0]  border_clr_i,
  input  logic [PIX_W-1:0]  underflow_clr_i,
  input  logic [PIX_W-1:0]  pix_data_i,
  input  logic              pix_valid_i,
  output logic              pix_ready_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              den_o,
  output logic              act_o,
  output logic              fetch_o,
  output logic [PIX_W-1:0]  pix_o,
  output logic [FCNT_W-1:0] frame_cnt_o,
  output logic [H_W-1:0]    line_cnt_o
);
  vtg_timing_t raw_cfg, sh_cfg;
  logic run, load;
  logic [OFS_W-1:0] pos;
  logic [H_W-1:0]   hpos;
  logic dh_in, ah_in, dv_in, av_in;
  logic den_raw, act_raw;

  always_comb begin
    raw_cfg.h_period  = hsync_ctl_i[31:16];
    raw_cfg.h_pulse   = hsync_ctl_i[15:0];
    raw_cfg.dh_end    = disp_hwin_i[31:16];
    raw_cfg.dh_start  = disp_hwin_i[15:0];
    raw_cfg.ah_end    = act_hwin_i[31:16];
    raw_cfg.ah_start  = act_hwin_i[15:0];
    raw_cfg.f_len     = frame_len_i;
    raw_cfg.vs_len    = vs_len_i;
    raw_cfg.dv_start  = disp_vstart_i;
    raw_cfg.dv_end    = disp_vend_i;
    raw_cfg.av_start  = act_vstart_i;
    raw_cfg.av_end    = act_vend_i;
    raw_cfg.fetch_pos = fetch_pos_i;
    raw_cfg.ah_en     = ctrl_i[0];
    raw_cfg.av_en     = ctrl_i[1];
    raw_cfg.fetch_en  = ctrl_i[2];
  end

  vtg_shadow u_shadow (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .raw_i(raw_cfg), .sh_o(sh_cfg)
  );

  vtg_counters #(.FCNT_W(FCNT_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .sh_i(sh_cfg),
    .run_o(run), .load_o(load), .pos_o(pos), .h_o(hpos),
    .line_o(line_cnt_o), .frame_o(frame_cnt_o)
  );

  vtg_window #(.W(H_W)) u_dh (
    .val_i(hpos), .lo_i(sh_cfg.dh_start), .hi_i(sh_cfg.dh_end), .in_o(dh_in));
  vtg_window #(.W(H_W)) u_ah (
    .val_i(hpos), .lo_i(sh_cfg.ah_start), .hi_i(sh_cfg.ah_end), .in_o(ah_in));
  vtg_window #(.W(OFS_W)) u_dv (
    .val_i(pos), .lo_i(sh_cfg.dv_start), .hi_i(sh_cfg.dv_end), .in_o(dv_in));
  vtg_window #(.W(OFS_W)) u_av (
    .val_i(pos), .lo_i(sh_cfg.av_start), .hi_i(sh_cfg.av_end), .in_o(av_in));

  assign den_raw = run & dv_in & dh_in;
  assign act_raw = den_raw & (~sh_cfg.ah_en | ah_in) & (~sh_cfg.av_en | av_in);

  assign hsync_o     = (run & (hpos < sh_cfg.h_pulse)) ^ polarity_i[0];
  assign vsync_o     = (run & (pos < sh_cfg.vs_len)) ^ polarity_i[1];
  assign den_o       = den_raw ^ polarity_i[2];
  assign act_o       = act_raw;
  assign pix_ready_o = act_raw;
  assign fetch_o     = run & sh_cfg.fetch_en & (pos == sh_cfg.fetch_pos);

  vtg_pixel #(.PIX_W(PIX_W)) u_pix (
    .den_i(den_raw), .act_i(act_raw), .valid_i(pix_valid_i), .data_i(pix_data_i),
    .border_i(border_clr_i), .underflow_i(underflow_clr_i), .pix_o(pix_o)
  );
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker #(
  parameter int unsigned PIX_W  = 24,
  parameter int unsigned FCNT_W = 16,
  parameter int unsigned LCNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [2:0]        polarity_i,
  input logic              pix_valid_i,
  input logic [PIX_W-1:0]  pix_data_i,
  input logic [PIX_W-1:0]  underflow_clr_i,
  input logic              pix_ready_o,
  input logic              den_o,
  input logic              fetch_o,
  input logic [PIX_W-1:0]  pix_o,
  input logic [FCNT_W-1:0] frame_cnt_o,
  input logic [LCNT_W-1:0] line_cnt_o
);
  a_r7_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (frame_cnt_o == '0 && line_cnt_o == '0 && !fetch_o));

  a_r5_take_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_ready_o && pix_valid_i) |-> pix_o == pix_data_i);

  a_r5_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_ready_o && !pix_valid_i) |-> pix_o == underflow_clr_i);

  a_r5_ready_in_den: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_ready_o |-> (den_o != polarity_i[2]));

  a_r4_blank_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (den_o == polarity_i[2]) |-> pix_o == '0);

  a_r9_frame_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_cnt_o != $past(frame_cnt_o)) |->
      (frame_cnt_o == $past(frame_cnt_o) + 1'b1 || frame_cnt_o == '0));

  a_r9_line_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_cnt_o != $past(line_cnt_o)) |->
      (line_cnt_o == $past(line_cnt_o) + 1'b1 || line_cnt_o == '0));
endmodule

bind vtg_top vtg_checker #(.PIX_W(PIX_W), .FCNT_W(FCNT_W), .LCNT_W(vtg_pkg::H_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .polarity_i(polarity_i),
  .pix_valid_i(pix_valid_i), .pix_data_i(pix_data_i), .underflow_clr_i(underflow_clr_i),
  .pix_ready_o(pix_ready_o), .den_o(den_o), .fetch_o(fetch_o), .pix_o(pix_o),
  .frame_cnt_o(frame_cnt_o), .line_cnt_o(line_cnt_o)
);

// File: tb/tb_vtg_top.sv
module tb_vtg_top;
  import vtg_pkg::*;
  localparam int PW = 24;
  localparam int FW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic en;
  logic [31:0] hsync_ctl, disp_hwin, act_hwin;
  logic [2:0] ctrl, pol;
  logic [OFS_W-1:0] flen, vslen, dvs, dve, avs, ave, fpos;
  logic [PW-1:0] border, uflow, pdata;
  logic pvalid;
  logic pready, hs, vs, den, act, fetch;
  logic [PW-1:0] pix;
  logic [FW-1:0] fcnt;
  logic [H_W-1:0] lcnt;

  vtg_top #(.PIX_W(PW), .FCNT_W(FW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .hsync_ctl_i(hsync_ctl),
    .disp_hwin_i(disp_hwin), .act_hwin_i(act_hwin), .ctrl_i(ctrl),
    .frame_len_i(flen), .vs_len_i(vslen), .disp_vstart_i(dvs), .disp_vend_i(dve),
    .act_vstart_i(avs), .act_vend_i(ave), .fetch_pos_i(fpos), .polarity_i(pol),
    .border_clr_i(border), .underflow_clr_i(uflow), .pix_data_i(pdata),
    .pix_valid_i(pvalid), .pix_ready_o(pready), .hsync_o(hs), .vsync_o(vs),
    .den_o(den), .act_o(act), .fetch_o(fetch), .pix_o(pix),
    .frame_cnt_o(fcnt), .line_cnt_o(lcnt)
  );

  int errs = 0, checks = 0, cyc = 0, vmode = 0;
  string phase = "reset";

  typedef struct {
    bit run, hs, vs, den, act, fetch;
    int frame, line;
  } exp_t;
  exp_t q[$];

  task automatic chk(string tag, longint a, longint e);
    checks++;
    if (a != e) begin
      errs++;
      $display("FAIL %s (%s) actual=%0h expected=%0h", tag, phase, a, e);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  // reference model: shadow values, flat position, per-cycle expectations
  int m_hper, m_hpul, m_dhs, m_dhe, m_ahs, m_ahe;
  int m_flen, m_vsl, m_dvs, m_dve, m_avs, m_ave, m_fpos;
  bit m_ahen, m_aven, m_fen, m_run;
  int m_pos, m_frame;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n || !en) begin
      m_run = 0; m_pos = 0; m_frame = 0;
    end else if (!m_run || m_pos == m_flen - 1) begin
      m_run = 1; m_pos = 0; m_frame = (m_frame + 1) % 65536;
      m_hper = int'(hsync_ctl[31:16]); m_hpul = int'(hsync_ctl[15:0]);
      m_dhe = int'(disp_hwin[31:16]); m_dhs = int'(disp_hwin[15:0]);
      m_ahe = int'(act_hwin[31:16]);  m_ahs = int'(act_hwin[15:0]);
      m_flen = int'(flen); m_vsl = int'(vslen); m_dvs = int'(dvs); m_dve = int'(dve);
      m_avs = int'(avs); m_ave = int'(ave); m_fpos = int'(fpos);
      m_ahen = ctrl[0]; m_aven = ctrl[1]; m_fen = ctrl[2];
    end else begin
      m_pos++;
    end
    if (rst_n) begin
      exp_t e;
      int hp;
      hp = m_run ? (m_pos % m_hper) : 0;
      e.run   = m_run;
      e.hs    = m_run && hp < m_hpul;
      e.vs    = m_run && m_pos < m_vsl;
      e.den   = m_run && m_pos >= m_dvs && m_pos <= m_dve && hp >= m_dhs && hp <= m_dhe;
      e.act   = e.den && (!m_ahen || (hp >= m_ahs && hp <= m_ahe))
                      && (!m_aven || (m_pos >= m_avs && m_pos <= m_ave));
      e.fetch = m_run && m_fen && m_pos == m_fpos;
      e.frame = m_frame;
      e.line  = m_run ? m_pos / m_hper : 0;
      q.push_back(e);
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      logic [PW-1:0] ep;
      e = q.pop_front();
      chk("R1 R6 hsync", hs, e.hs ^ pol[0]);
      chk("R2 R6 vsync", vs, e.vs ^ pol[1]);
      chk("R3 R6 den", den, e.den ^ pol[2]);
      chk("R4 R5 act", act, e.act);
      chk("R5 ready", pready, e.act);
      if (!e.den)       ep = '0;
      else if (!e.act)  ep = border;
      else if (pvalid)  ep = pdata;
      else              ep = uflow;
      chk((e.den && !e.act) ? "R4 border pix" : "R5 pix", pix, ep);
      chk("R8 fetch", fetch, e.fetch);
      chk(e.run ? "R9 frame" : "R7 frame idle", fcnt, e.frame);
      chk(e.run ? "R9 line" : "R7 line idle", lcnt, e.line);
    end
  end

  // stream driver
  always @(posedge clk) begin
    #2;
    pdata  <= PW'(cyc * 37 + 5);
    pvalid <= (vmode == 0) ? 1'b1 : ((cyc % 3) != 0);
  end

  task automatic geom_a();
    hsync_ctl = {16'd12, 16'd2};  disp_hwin = {16'd9, 16'd4};  act_hwin = {16'd8, 16'd5};
    flen = 96; vslen = 12; dvs = 24; dve = 71; avs = 36; ave = 59; fpos = 80;
  endtask

  task automatic geom_b();
    hsync_ctl = {16'd16, 16'd3};  disp_hwin = {16'd13, 16'd6}; act_hwin = {16'd12, 16'd7};
    flen = 128; vslen = 16; dvs = 32; dve = 95; avs = 48; ave = 79; fpos = 110;
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    en = 0; ctrl = 3'b000; pol = 3'b000; border = 24'hB0B0B0; uflow = 24'hFF0033;
    pdata = '0; pvalid = 1'b0;
    geom_a();
    repeat (3) begin
      @(negedge clk);
      chk("R7 reset hsync", hs, 0);
      chk("R7 reset vsync", vs, 0);
      chk("R7 reset den", den, 0);
      chk("R7 reset frame", fcnt, 0);
      chk("R5 reset ready", pready, 0);
      chk("R4 reset pix", pix, 0);
    end
    step(1);
    rst_n = 1;
    step(3);
    phase = "R3 full image"; en = 1;
    step(2 * 96 + 10);
    phase = "R4 R5 R8 border starve"; ctrl = 3'b111; vmode = 1;
    step(2 * 96 + 10);
    phase = "R6 polarity"; pol = 3'b111;
    step(100);
    pol = 3'b101;
    step(30);
    pol = 3'b000;
    phase = "R10 mid-frame change";
    step(40);
    geom_b();
    step(3 * 128);
    phase = "R7 disable restart"; en = 0;
    step(10);
    en = 1;
    step(150);
    en = 0;
    step(5);
    summary();
    $finish;
  end

  initial begin
    #2_000_000;
    errs++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    summary();
    $finish;
  end
endmodule